// File: doc/BRIEF.md
# Low-Power-Domain Reset Control Registers

This block is a small register file on a plain 32-bit register bus. It gathers the software-controlled resets of a low-power domain and drives one interrupt line. Software uses the registers to hold or release two processor cores, a set of DMA channels and a row of peripherals, and to manage a single fault interrupt. Each reset field drives its target as a level output. The core, DMA and peripheral fields also produce a one-cycle pulse in the cycle after a write changes their value. A write that leaves a field at its old value does nothing to the target.

The interrupt has one status bit. A hardware fault input sets it, and software clears it by writing a one. The mask for the interrupt cannot be written directly. Software clears it through an enable register and sets it through a disable register, and both of those registers read back as zero. Reads are combinational: `bus_rdata` shows the register selected by `bus_addr` in the same cycle.

Top module: `lpd_rst_regs`

## Requirements
- R1: After `rst_n` is asserted, reads return the reset values. Status is 0 and mask is 1, so `irq_o` is 0. Core register 0x10 reads 0x17 and DMA register 0x14 reads 1. Every peripheral register reads 1. Timer register 0x60 reads 0xF, debug register 0x64 reads 0x33 and full-domain register 0x68 reads 0x3. All pulse outputs are 0.
- R2: Bit 0 of offset 0x00 is the status bit. It is set in the cycle after `fault_in` is high. It is cleared by a write whose bit 0 is 1, and a set in the same cycle wins over the clear. `irq_o` is high exactly when status is 1 and mask is 0.
- R3: Bit 0 of offset 0x04 is the mask. A write to 0x04 leaves the mask unchanged.
- R4: Writing 1 in bit 0 of offset 0x08 clears the mask. Writing 1 in bit 0 of offset 0x0C sets it. A 0 in bit 0 has no effect. Both offsets read as zero.
- R5: At offset 0x10, bits 0 and 1 are the hold-in-reset fields for core 0 and core 1. They drive `core_rst_o`. Bits 2 and 4 are stored, and bit 3 and the bits above 4 read zero. `core_pulse_o[i]` is high for one cycle after a write that changes bit i, and it stays low after a write that keeps the bit's value.
- R6: Bit 0 of offset 0x14 drives every bit of `dma_rst_o` at once. Every bit of `dma_pulse_o` pulses for one cycle when a write changes that bit.
- R7: Peripheral i has a reset field at bit 0 of offset 0x20+4*i. The field drives `periph_rst_o[i]`. `periph_pulse_o[i]` pulses for one cycle only when a write changes the field.
- R8: Offset 0x60 bits 3:0 drive `tmr_rst_o`. Offset 0x64 keeps only the bits in 0x33 and drives `dbg_rst_o`. Offset 0x68 bits 1:0 drive `fpd_rst_o`. Bits outside these fields read zero and ignore writes.
- R9: An access with `bus_addr[1:0]` not zero, or to an unmapped offset, reads zero and changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe for the current cycle |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| fault_in | input | 1 | Sets the interrupt status bit |
| irq_o | output | 1 | Interrupt, status and not mask |
| core_rst_o | output | 2 | Core hold-in-reset levels |
| core_pulse_o | output | 2 | One-cycle pulse when a core field changes |
| dma_rst_o | output | N_DMA | DMA channel reset levels |
| dma_pulse_o | output | N_DMA | One-cycle pulse when the DMA field changes |
| periph_rst_o | output | N_PERIPH | Peripheral reset levels |
| periph_pulse_o | output | N_PERIPH | One-cycle pulse when a peripheral field changes |
| tmr_rst_o | output | 4 | Timer reset levels |
| dbg_rst_o | output | 8 | Debug reset levels (bits in 0x33) |
| fpd_rst_o | output | 2 | Full-power-domain reset levels |

## Verification
The bench aims at writes that keep a field at its old value. A design that pulses on every write instead of on every change would reset a running core or peripheral for no reason. It drives `fault_in` in the same cycle as a clearing write; if the clear wins, the design loses a fault. It writes straight to the mask offset and writes zeros to the enable and disable registers; a design that lets either change the mask would unmask the interrupt without being asked. Misaligned writes, unmapped writes and all-ones writes into reserved bits show whether a design corrupts neighbouring fields or leaks reserved bits onto the reset outputs.

// File: rtl/lpd_rst_regs.sv
module lpd_rst_regs #(
  parameter int N_DMA    = 8,
  parameter int N_PERIPH = 14
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_we,
  input  logic [7:0]          bus_addr,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  input  logic                fault_in,
  output logic                irq_o,
  output logic [1:0]          core_rst_o,
  output logic [1:0]          core_pulse_o,
  output logic [N_DMA-1:0]    dma_rst_o,
  output logic [N_DMA-1:0]    dma_pulse_o,
  output logic [N_PERIPH-1:0] periph_rst_o,
  output logic [N_PERIPH-1:0] periph_pulse_o,
  output logic [3:0]          tmr_rst_o,
  output logic [7:0]          dbg_rst_o,
  output logic [1:0]          fpd_rst_o
);
  localparam logic [5:0] IX_STAT = 6'd0;
  localparam logic [5:0] IX_MASK = 6'd1;
  localparam logic [5:0] IX_EN   = 6'd2;
  localparam logic [5:0] IX_DIS  = 6'd3;
  localparam logic [5:0] IX_CORE = 6'd4;
  localparam logic [5:0] IX_DMA  = 6'd5;
  localparam int         IX_PER0 = 8;
  localparam logic [5:0] IX_TMR  = 6'd24;
  localparam logic [5:0] IX_DBG  = 6'd25;
  localparam logic [5:0] IX_FPD  = 6'd26;
  localparam logic [4:0] CORE_KEEP = 5'h17;
  localparam logic [7:0] DBG_KEEP  = 8'h33;

  logic       aligned, wr_ok;
  logic [5:0] widx;
  logic       stat_q, mask_q, dma_q, dma_pulse_q;
  logic [4:0] core_q;
  logic [1:0] core_pulse_q;
  logic [3:0] tmr_q;
  logic [7:0] dbg_q;
  logic [1:0] fpd_q;
  logic [N_PERIPH-1:0] per_q, per_pulse_q;
  logic       unused_wdata;

  assign aligned      = (bus_addr[1:0] == 2'b00);
  assign widx         = bus_addr[7:2];
  assign wr_ok        = bus_we & aligned;
  assign unused_wdata = ^bus_wdata[31:8];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) stat_q <= 1'b0;
    else        stat_q <= fault_in | (stat_q & ~(wr_ok && widx == IX_STAT && bus_wdata[0]));

  AST_FAULT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    fault_in |=> stat_q); // R2
  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && widx == IX_STAT && bus_wdata[0] && !fault_in) |=> !irq_o); // R2

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                                         mask_q <= 1'b1;
    else if (wr_ok && widx == IX_EN  && bus_wdata[0])   mask_q <= 1'b0;
    else if (wr_ok && widx == IX_DIS && bus_wdata[0])   mask_q <= 1'b1;

  AST_MASK_RO: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && widx == IX_MASK) |=> $stable(mask_q)); // R3
  AST_EN_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && widx == IX_EN && bus_wdata[0]) |=> !mask_q); // R4
  AST_DIS_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && widx == IX_DIS && bus_wdata[0]) |=> mask_q); // R4

  assign irq_o = stat_q & ~mask_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      core_q       <= CORE_KEEP;
      core_pulse_q <= 2'b00;
    end else begin
      core_pulse_q <= 2'b00;
      if (wr_ok && widx == IX_CORE) begin
        core_q       <= bus_wdata[4:0] & CORE_KEEP;
        core_pulse_q <= bus_wdata[1:0] ^ core_q[1:0];
      end
    end

  assign core_rst_o   = core_q[1:0];
  assign core_pulse_o = core_pulse_q;

  for (genvar c = 0; c < 2; c++) begin : g_core_chk
    AST_CORE_PULSE_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      core_pulse_o[c] |-> (core_rst_o[c] != $past(core_rst_o[c]))); // R5
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      dma_q       <= 1'b1;
      dma_pulse_q <= 1'b0;
    end else begin
      dma_pulse_q <= wr_ok && widx == IX_DMA && (bus_wdata[0] != dma_q);
      if (wr_ok && widx == IX_DMA) dma_q <= bus_wdata[0];
    end

  assign dma_rst_o   = {N_DMA{dma_q}};
  assign dma_pulse_o = {N_DMA{dma_pulse_q}};

  AST_DMA_PULSE_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    dma_pulse_o[0] |-> (dma_rst_o[N_DMA-1] != $past(dma_rst_o[N_DMA-1]))); // R6

  for (genvar g = 0; g < N_PERIPH; g++) begin : g_per
    localparam logic [5:0] IX = 6'(IX_PER0 + g);
    logic hit;
    assign hit = wr_ok && widx == IX;

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        per_q[g]       <= 1'b1;
        per_pulse_q[g] <= 1'b0;
      end else begin
        per_pulse_q[g] <= hit && (bus_wdata[0] != per_q[g]);
        if (hit) per_q[g] <= bus_wdata[0];
      end

    AST_PER_PULSE_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      periph_pulse_o[g] |-> (periph_rst_o[g] != $past(periph_rst_o[g]))); // R7
    AST_PER_SAME_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && bus_wdata[0] == periph_rst_o[g]) |=> !periph_pulse_o[g]); // R7
  end

  assign periph_rst_o   = per_q;
  assign periph_pulse_o = per_pulse_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tmr_q <= 4'hF;
      dbg_q <= DBG_KEEP;
      fpd_q <= 2'b11;
    end else if (wr_ok) begin
      if (widx == IX_TMR) tmr_q <= bus_wdata[3:0];
      if (widx == IX_DBG) dbg_q <= bus_wdata[7:0] & DBG_KEEP;
      if (widx == IX_FPD) fpd_q <= bus_wdata[1:0];
    end

  assign tmr_rst_o = tmr_q;
  assign dbg_rst_o = dbg_q;
  assign fpd_rst_o = fpd_q;

  AST_DBG_RSVD: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_rst_o & ~DBG_KEEP) == 8'h00); // R8

  always_comb begin
    bus_rdata = 32'h0;
    if (aligned) begin
      unique case (widx)
        IX_STAT: bus_rdata[0]   = stat_q;
        IX_MASK: bus_rdata[0]   = mask_q;
        IX_CORE: bus_rdata[4:0] = core_q;
        IX_DMA:  bus_rdata[0]   = dma_q;
        IX_TMR:  bus_rdata[3:0] = tmr_q;
        IX_DBG:  bus_rdata[7:0] = dbg_q;
        IX_FPD:  bus_rdata[1:0] = fpd_q;
        default:
          for (int i = 0; i < N_PERIPH; i++)
            if (widx == 6'(IX_PER0 + i)) bus_rdata[0] = per_q[i];
      endcase
    end
  end

  AST_MISALIGNED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !aligned |-> (bus_rdata == 32'h0)); // R9
  AST_MISALIGNED_NOWRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && !aligned && !fault_in) |=> ($stable(core_rst_o) && $stable(periph_rst_o) && $stable(irq_o))); // R9
endmodule

// File: tb/lpd_rst_regs_tb_top.sv
module lpd_rst_regs_tb_top;
  localparam int ND = 8;
  localparam int NP = 14;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_we = 1'b0, fault_in = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic [31:0] bus_wdata = 32'h0;
  logic [31:0] bus_rdata;
  logic irq_o;
  logic [1:0] core_rst_o, core_pulse_o, fpd_rst_o;
  logic [ND-1:0] dma_rst_o, dma_pulse_o;
  logic [NP-1:0] periph_rst_o, periph_pulse_o;
  logic [3:0] tmr_rst_o;
  logic [7:0] dbg_rst_o;

  lpd_rst_regs #(.N_DMA(ND), .N_PERIPH(NP)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .fault_in(fault_in),
    .irq_o(irq_o), .core_rst_o(core_rst_o), .core_pulse_o(core_pulse_o),
    .dma_rst_o(dma_rst_o), .dma_pulse_o(dma_pulse_o),
    .periph_rst_o(periph_rst_o), .periph_pulse_o(periph_pulse_o),
    .tmr_rst_o(tmr_rst_o), .dbg_rst_o(dbg_rst_o), .fpd_rst_o(fpd_rst_o));

  always #2 clk = ~clk;

  int checks = 0, bad = 0;
  bit finished = 0;
  string phase_tag = "";

  bit m_stat, m_mask, m_dma, m_dpul;
  bit [4:0] m_core;
  bit [1:0] m_cpul, m_fpd;
  bit [NP-1:0] m_per, m_ppul;
  bit [3:0] m_tmr;
  bit [7:0] m_dbg;

  task automatic m_reset();
    m_stat = 0; m_mask = 1; m_dma = 1; m_dpul = 0;
    m_core = 5'h17; m_cpul = 0; m_fpd = 2'h3;
    m_per = '1; m_ppul = '0; m_tmr = 4'hF; m_dbg = 8'h33;
  endtask

  function automatic int per_of(input logic [7:0] a);
    if (a[1:0] != 0) return -1;
    if (a >= 8'h20 && int'(a) < 32 + 4 * NP) return (int'(a) - 32) / 4;
    return -1;
  endfunction

  function automatic logic [31:0] exp_rd(input logic [7:0] a);
    if (a[1:0] != 0) return 0;
    if (per_of(a) >= 0) return {31'b0, m_per[per_of(a)]};
    case (a)
      8'h00: return {31'b0, m_stat};
      8'h04: return {31'b0, m_mask};
      8'h10: return {27'b0, m_core};
      8'h14: return {31'b0, m_dma};
      8'h60: return {28'b0, m_tmr};
      8'h64: return {24'b0, m_dbg};
      8'h68: return {30'b0, m_fpd};
      default: return 0;
    endcase
  endfunction

  function automatic string rd_tag(input logic [7:0] a);
    if (phase_tag != "") return phase_tag;
    if (a[1:0] != 0) return "R9";
    if (per_of(a) >= 0) return "R7";
    case (a)
      8'h00: return "R2";
      8'h04: return "R3";
      8'h08, 8'h0C: return "R4";
      8'h10: return "R5";
      8'h14: return "R6";
      8'h60, 8'h64, 8'h68: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s at %0t: actual=%h expected=%h", tag, what, $time, act, exp);
    end
  endtask

  always begin
    @(posedge clk);
    if (!rst_n) m_reset();
    else begin
      automatic bit w = bus_we && bus_addr[1:0] == 0;
      automatic int p = per_of(bus_addr);
      m_cpul = (w && bus_addr == 8'h10) ? (bus_wdata[1:0] ^ m_core[1:0]) : 2'b00;
      m_dpul = w && bus_addr == 8'h14 && bus_wdata[0] != m_dma;
      m_ppul = '0;
      if (w && p >= 0) begin
        m_ppul[p] = bus_wdata[0] != m_per[p];
        m_per[p] = bus_wdata[0];
      end
      m_stat = fault_in || (m_stat && !(w && bus_addr == 8'h00 && bus_wdata[0]));
      if (w && bus_addr == 8'h08 && bus_wdata[0]) m_mask = 0;
      if (w && bus_addr == 8'h0C && bus_wdata[0]) m_mask = 1;
      if (w && bus_addr == 8'h10) m_core = bus_wdata[4:0] & 5'h17;
      if (w && bus_addr == 8'h14) m_dma = bus_wdata[0];
      if (w && bus_addr == 8'h60) m_tmr = bus_wdata[3:0];
      if (w && bus_addr == 8'h64) m_dbg = bus_wdata[7:0] & 8'h33;
      if (w && bus_addr == 8'h68) m_fpd = bus_wdata[1:0];
    end
    #1;
    if (!finished) begin
      chk(phase_tag != "" ? phase_tag : "R2", "irq_o", {31'b0, irq_o}, {31'b0, m_stat & ~m_mask});
      chk(rd_tag(bus_addr), "bus_rdata", bus_rdata, exp_rd(bus_addr));
      chk("R5", "core_rst_o", {30'b0, core_rst_o}, {30'b0, m_core[1:0]});
      chk("R5", "core_pulse_o", {30'b0, core_pulse_o}, {30'b0, m_cpul});
      chk("R6", "dma_rst_o", 32'(dma_rst_o), m_dma ? 32'((1 << ND) - 1) : 32'h0);
      chk("R6", "dma_pulse_o", 32'(dma_pulse_o), m_dpul ? 32'((1 << ND) - 1) : 32'h0);
      chk("R7", "periph_rst_o", 32'(periph_rst_o), 32'(m_per));
      chk("R7", "periph_pulse_o", 32'(periph_pulse_o), 32'(m_ppul));
      chk("R8", "tmr/dbg/fpd", {18'b0, tmr_rst_o, dbg_rst_o, fpd_rst_o}, {18'b0, m_tmr, m_dbg, m_fpd});
    end
  end

  task automatic drive(input bit we, input logic [7:0] a, input logic [31:0] d, input bit f);
    @(negedge clk);
    bus_we = we; bus_addr = a; bus_wdata = d; fault_in = f;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    drive(1, a, d, 0);
    drive(0, a, 32'h0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    phase_tag = "R1";
    for (int a = 0; a < 8'h74; a += 4) drive(0, 8'(a), 0, 0);
    phase_tag = "";
    // R2/R4: masked fault, then unmask
    drive(0, 8'h00, 0, 1);
    drive(0, 8'h00, 0, 0);
    wr(8'h08, 32'h0);
    wr(8'h08, 32'h1);
    wr(8'h00, 32'hFFFF_FFFE);
    wr(8'h00, 32'h1);
    drive(0, 8'h00, 0, 1);
    drive(1, 8'h00, 32'h1, 1);
    drive(0, 8'h00, 0, 0);
    // R3: direct mask write
    wr(8'h04, 32'h1);
    wr(8'h0C, 32'h0);
    wr(8'h0C, 32'h1);
    wr(8'h04, 32'h0);
    drive(0, 8'h0C, 0, 0);
    // R5
    wr(8'h10, 32'h17);
    wr(8'h10, 32'h15);
    wr(8'h10, 32'hFFFF_FFFF);
    wr(8'h10, 32'h0);
    wr(8'h10, 32'h2);
    // R6
    wr(8'h14, 32'h0);
    wr(8'h14, 32'h0);
    wr(8'h14, 32'h1);
    // R7
    for (int i = 0; i < NP; i++) begin
      wr(8'(32 + 4 * i), 32'h0);
      wr(8'(32 + 4 * i), 32'h0);
      wr(8'(32 + 4 * i), 32'hFFFF_FFFF);
    end
    // R8
    wr(8'h60, 32'hFFFF_FFF0);
    wr(8'h64, 32'hFFFF_FFFF);
    wr(8'h64, 32'h0000_00CC);
    wr(8'h68, 32'hFFFF_FFFF);
    // R9
    wr(8'h21, 32'h0);
    wr(8'h11, 32'h0);
    wr(8'h0A, 32'h1);
    wr(8'h80, 32'hFFFF_FFFF);
    wr(8'hFC, 32'hFFFF_FFFF);
    drive(0, 8'h22, 0, 0);
    drive(0, 8'h13, 0, 0);
    // mixed traffic
    for (int n = 0; n < 3000; n++) begin
      automatic logic [7:0] a = ($urandom % 4 == 0) ? 8'($urandom) : 8'(4 * ($urandom % 28));
      drive($urandom % 2 == 0, a, $urandom, $urandom % 8 == 0);
    end
    // R1: reset in the middle of activity
    @(negedge clk);
    rst_n = 0;
    drive(0, 8'h00, 0, 0);
    drive(0, 8'h00, 0, 0);
    rst_n = 1;
    phase_tag = "R1";
    for (int a = 0; a < 8'h74; a += 4) drive(0, 8'(a), 0, 0);
    phase_tag = "";
    drive(0, 8'h00, 0, 0);
    @(negedge clk);
    finished = 1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end
endmodule